// File: doc/BRIEF.md
# MMU Control Register Bank

This block is the register file attached to one side of an address translation unit. One instance serves the instruction side and another the data side. The `IS_DATA` parameter picks which. The bank holds:

- the tag access register;
- the translation-table base (TSB) register, which is only stored and never interpreted here;
- the fault status register;
- the fault address register;
- on the data side only, the primary and secondary context registers.

Software reaches the bank through a 4-bit register index taken from address bits [6:3], with a write strobe and a read strobe. Read data appears in a register one cycle after the read strobe.

Two hardware inputs come from the lookup logic:

- A fault report updates the fault status register, and on the data side it also records the faulting address.
- A miss capture loads the tag access register with the missing virtual page and the current context.

The instruction side takes its context from the data-side primary context through `ctx_in`. The data side drives that value on `ctx_out`. Index 0 is never stored. A read of it returns a tag-target word that is rebuilt from the tag access register.

Top module: `mmu_ctl_bank`

## Requirements
- R1: After reset every index (0 to 15) reads back as zero.
- R2: On the data side the index map is as follows, and a written value reads back at the same index:
  - index 1: primary context, keeps bits [12:0] only;
  - index 2: secondary context, keeps bits [12:0] only;
  - index 3: fault status;
  - index 4: fault address;
  - index 5: TSB base;
  - index 6: tag access.
  
  Indices 7 to 15 read zero, and writes to them are ignored.
- R3: A read of index 0 returns tag access bits [12:0] at bit positions [60:48], ORed with the tag access register shifted right by 22. A write to index 0 has no effect.
- R4: The read strobe captures read data at the clock edge, and it is visible for the whole next cycle. Without a read strobe, the read data holds its value even when registers change.
- R5: A fault status write whose bit 0 is 0 clears the register to zero. With bit 0 set, the value is stored as written. On the data side, a clearing write also zeroes the fault address.
- R6: A fault report first replaces the fault status with 2 if its bit 0 was already set. It then ORs in bit 0 (valid), bit 2 (write access), bit 3 (user mode) and bits [8:7] (fault type, bit 7 = privilege violation).
- R7: On the data side a fault report loads the fault address register with `flt_va`. On the instruction side the fault address register stays zero.
- R8: A miss loads tag access with `miss_va` bits [63:13], with the 13-bit context in bits [12:0]. The context is the block's own primary context on the data side and `ctx_in` on the instruction side.
- R9: When a fault report or miss capture and a software write hit the same register in one cycle, the hardware capture wins.
- R10: On the instruction side, writes to indices 1, 2 and 4 have no effect and those indices read zero. Indices 3, 5 and 6 stay writable.
- R11: `ctx_out` equals the primary context register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register index, address bits [6:3] |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 64 | Registered read data |
| flt_valid | input | 1 | Fault report strobe |
| flt_user | input | 1 | Faulting access was in user mode |
| flt_write | input | 1 | Faulting access was a write |
| flt_type | input | 2 | Fault type code (bit 0 = privilege violation) |
| flt_va | input | 64 | Faulting virtual address |
| miss_valid | input | 1 | Miss capture strobe |
| miss_va | input | 64 | Missing virtual address |
| ctx_in | input | 13 | Context used by the instruction side for misses |
| ctx_out | output | 13 | Primary context |

## Verification
The assertions assume that `flt_valid` and `miss_valid` are single-cycle pulses from the lookup logic. They also assume that the read index is held only while `rd_en` is high. The bench drives every strobe for exactly one cycle, between falling edges. The fault-over-write and miss-over-write cases are the only stimulus in which a capture and a write to the same register coincide. Apart from those two cases, one fault and one miss never share a cycle.

// File: rtl/mmu_bank_pkg.sv
package mmu_bank_pkg;
  localparam int MMU_DW     = 64;
  localparam int CTX_W      = 13;
  localparam int IDX_W      = 4;
  localparam int IDX_LSB    = 3;
  localparam int TT_SHIFT   = 22;
  localparam int TT_CTX_POS = 48;
  localparam int FSR_VLD    = 0;
  localparam int FSR_WR     = 2;
  localparam int FSR_USR    = 3;
  localparam int FSR_FT     = 7;
  localparam logic [MMU_DW-1:0] FSR_OVF_CODE = 64'd2;

  typedef enum logic [IDX_W-1:0] {
    IX_TTGT = 4'd0,
    IX_PCTX = 4'd1,
    IX_SCTX = 4'd2,
    IX_FSR  = 4'd3,
    IX_FAR  = 4'd4,
    IX_TSB  = 4'd5,
    IX_TAG  = 4'd6
  } mmu_idx_e;

  // Synthesized read-only word for index 0
  function automatic logic [MMU_DW-1:0] tag_target(input logic [MMU_DW-1:0] ta);
    logic [MMU_DW-1:0] ctx_part;
    ctx_part = {{(MMU_DW-CTX_W){1'b0}}, ta[CTX_W-1:0]};
    return (ctx_part << TT_CTX_POS) | (ta >> TT_SHIFT);
  endfunction

  // Fault status after a reported fault
  function automatic logic [MMU_DW-1:0] fsr_on_fault(
    input logic [MMU_DW-1:0] cur,
    input logic              usr,
    input logic              wr,
    input logic [1:0]        ft
  );
    logic [MMU_DW-1:0] r;
    r = cur[FSR_VLD] ? FSR_OVF_CODE : cur;
    r[FSR_VLD]        = 1'b1;
    r[FSR_WR]         = r[FSR_WR] | wr;
    r[FSR_USR]        = r[FSR_USR] | usr;
    r[FSR_FT +: 2]    = r[FSR_FT +: 2] | ft;
    return r;
  endfunction

  // Tag access value captured on a miss
  function automatic logic [MMU_DW-1:0] miss_tag(
    input logic [MMU_DW-1:0] va,
    input logic [CTX_W-1:0]  ctx
  );
    return {va[MMU_DW-1:CTX_W], ctx};
  endfunction
endpackage

// File: rtl/mmu_fsr_unit.sv
module mmu_fsr_unit
  import mmu_bank_pkg::*;
#(
  parameter bit IS_DATA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fsr,
  input  logic              wr_far,
  input  logic [MMU_DW-1:0] wdata,
  input  logic              flt_valid,
  input  logic              flt_user,
  input  logic              flt_write,
  input  logic [1:0]        flt_type,
  input  logic [MMU_DW-1:0] flt_va,
  output logic [MMU_DW-1:0] fsr_q,
  output logic [MMU_DW-1:0] far_q
);
  logic fsr_clear_wr;
  assign fsr_clear_wr = wr_fsr && !wdata[FSR_VLD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q <= '0;
    end else if (flt_valid) begin
      fsr_q <= fsr_on_fault(fsr_q, flt_user, flt_write, flt_type);
    end else if (wr_fsr) begin
      fsr_q <= fsr_clear_wr ? '0 : wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !IS_DATA) begin
      far_q <= '0;
    end else if (flt_valid) begin
      far_q <= flt_va;
    end else if (fsr_clear_wr) begin
      far_q <= '0;
    end else if (wr_far) begin
      far_q <= wdata;
    end
  end
endmodule

// File: rtl/mmu_tag_unit.sv
module mmu_tag_unit
  import mmu_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_tag,
  input  logic              wr_tsb,
  input  logic [MMU_DW-1:0] wdata,
  input  logic              miss_valid,
  input  logic [MMU_DW-1:0] miss_va,
  input  logic [CTX_W-1:0]  miss_ctx,
  output logic [MMU_DW-1:0] tag_q,
  output logic [MMU_DW-1:0] tsb_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (miss_valid) begin
      tag_q <= miss_tag(miss_va, miss_ctx);
    end else if (wr_tag) begin
      tag_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsb_q <= '0;
    end else if (wr_tsb) begin
      tsb_q <= wdata;
    end
  end
endmodule

// File: rtl/mmu_rd_mux.sv
module mmu_rd_mux
  import mmu_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [CTX_W-1:0]  pri_q,
  input  logic [CTX_W-1:0]  sec_q,
  input  logic [MMU_DW-1:0] fsr_q,
  input  logic [MMU_DW-1:0] far_q,
  input  logic [MMU_DW-1:0] tsb_q,
  input  logic [MMU_DW-1:0] tag_q,
  output logic [MMU_DW-1:0] rd_data
);
  logic [MMU_DW-1:0] sel;

  always_comb begin
    case (rd_idx)
      IX_TTGT: sel = tag_target(tag_q);
      IX_PCTX: sel = {{(MMU_DW-CTX_W){1'b0}}, pri_q};
      IX_SCTX: sel = {{(MMU_DW-CTX_W){1'b0}}, sec_q};
      IX_FSR:  sel = fsr_q;
      IX_FAR:  sel = far_q;
      IX_TSB:  sel = tsb_q;
      IX_TAG:  sel = tag_q;
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= sel;
    end
  end
endmodule

// File: rtl/mmu_ctl_bank.sv
module mmu_ctl_bank
  import mmu_bank_pkg::*;
#(
  parameter bit IS_DATA = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDX_LSB+IDX_W-1:IDX_LSB] reg_addr,
  input  logic                      wr_en,
  input  logic [MMU_DW-1:0]         wr_data,
  input  logic                      rd_en,
  output logic [MMU_DW-1:0]         rd_data,
  input  logic                      flt_valid,
  input  logic                      flt_user,
  input  logic                      flt_write,
  input  logic [1:0]                flt_type,
  input  logic [MMU_DW-1:0]         flt_va,
  input  logic                      miss_valid,
  input  logic [MMU_DW-1:0]         miss_va,
  input  logic [CTX_W-1:0]          ctx_in,
  output logic [CTX_W-1:0]          ctx_out
);
  logic [IDX_W-1:0]  idx;
  logic              wr_pri, wr_sec, wr_fsr, wr_far, wr_tsb, wr_tag;
  logic [CTX_W-1:0]  pri_q, sec_q, miss_ctx;
  logic [MMU_DW-1:0] fsr_q, far_q, tsb_q, tag_q;

  assign idx = reg_addr;

  // Write decode: data-only registers are gated off on the instruction side
  assign wr_pri = wr_en && (idx == IX_PCTX) && IS_DATA;
  assign wr_sec = wr_en && (idx == IX_SCTX) && IS_DATA;
  assign wr_far = wr_en && (idx == IX_FAR)  && IS_DATA;
  assign wr_fsr = wr_en && (idx == IX_FSR);
  assign wr_tsb = wr_en && (idx == IX_TSB);
  assign wr_tag = wr_en && (idx == IX_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
    end else begin
      if (wr_pri) pri_q <= wr_data[CTX_W-1:0];
      if (wr_sec) sec_q <= wr_data[CTX_W-1:0];
    end
  end

  assign miss_ctx = IS_DATA ? pri_q : ctx_in;
  assign ctx_out  = pri_q;

  mmu_fsr_unit #(.IS_DATA(IS_DATA)) u_fsr (
    .clk(clk), .rst_n(rst_n), .wr_fsr(wr_fsr), .wr_far(wr_far), .wdata(wr_data),
    .flt_valid(flt_valid), .flt_user(flt_user), .flt_write(flt_write),
    .flt_type(flt_type), .flt_va(flt_va), .fsr_q(fsr_q), .far_q(far_q)
  );

  mmu_tag_unit u_tag (
    .clk(clk), .rst_n(rst_n), .wr_tag(wr_tag), .wr_tsb(wr_tsb), .wdata(wr_data),
    .miss_valid(miss_valid), .miss_va(miss_va), .miss_ctx(miss_ctx),
    .tag_q(tag_q), .tsb_q(tsb_q)
  );

  mmu_rd_mux u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(idx),
    .pri_q(pri_q), .sec_q(sec_q), .fsr_q(fsr_q), .far_q(far_q),
    .tsb_q(tsb_q), .tag_q(tag_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/mmu_ctl_bank_chk.sv
module mmu_ctl_bank_chk
  import mmu_bank_pkg::*;
#(
  parameter bit IS_DATA = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [IDX_W-1:0]         idx,
  input logic                     wr_en,
  input logic                     wr_lsb,
  input logic                     rd_en,
  input logic [MMU_DW-1:0]        rd_data,
  input logic                     flt_valid,
  input logic                     flt_user,
  input logic [1:0]               flt_type,
  input logic [MMU_DW-1:0]        flt_va,
  input logic                     miss_valid,
  input logic [MMU_DW-1:CTX_W]    miss_va_hi,
  input logic [CTX_W-1:0]         miss_ctx,
  input logic [MMU_DW-1:0]        fsr_q,
  input logic [MMU_DW-1:0]        far_q,
  input logic [MMU_DW-1:0]        tag_q
);
  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_fault_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> fsr_q[FSR_VLD] && (fsr_q[FSR_USR] == $past(flt_user))
                  && (fsr_q[FSR_FT +: 2] == $past(flt_type)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && fsr_q[FSR_VLD]) |=> fsr_q[1]);

  p_fsr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IX_FSR && !wr_lsb && !flt_valid) |=> (fsr_q == '0));

  p_far_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && IS_DATA) |=> (far_q == $past(flt_va)));

  p_miss_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> (tag_q[MMU_DW-1:CTX_W] == $past(miss_va_hi))
                   && (tag_q[CTX_W-1:0] == $past(miss_ctx)));

  p_miss_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && wr_en && idx == IX_TAG) |=> (tag_q[CTX_W-1:0] == $past(miss_ctx)));
endmodule

bind mmu_ctl_bank mmu_ctl_bank_chk #(.IS_DATA(IS_DATA)) u_chk (
  .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .wr_lsb(wr_data[0]),
  .rd_en(rd_en), .rd_data(rd_data), .flt_valid(flt_valid), .flt_user(flt_user),
  .flt_type(flt_type), .flt_va(flt_va), .miss_valid(miss_valid),
  .miss_va_hi(miss_va[63:13]), .miss_ctx(miss_ctx), .fsr_q(fsr_q),
  .far_q(far_q), .tag_q(tag_q)
);

// File: tb/mmu_ctl_bank_tb.sv
module mmu_ctl_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // data-side signals
  logic [3:0]  d_addr = '0;
  logic        d_wr = 0, d_rd = 0, d_fv = 0, d_fu = 0, d_fw = 0, d_mv = 0;
  logic [1:0]  d_ft = '0;
  logic [63:0] d_wdata = '0, d_fva = '0, d_mva = '0, d_rdata;
  logic [12:0] d_ctx_out;
  // instruction-side signals
  logic [3:0]  i_addr = '0;
  logic        i_wr = 0, i_rd = 0, i_fv = 0, i_fu = 0, i_fw = 0, i_mv = 0;
  logic [1:0]  i_ft = '0;
  logic [63:0] i_wdata = '0, i_fva = '0, i_mva = '0, i_rdata;
  logic [12:0] i_ctx_out;

  mmu_ctl_bank #(.IS_DATA(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(d_addr), .wr_en(d_wr), .wr_data(d_wdata),
    .rd_en(d_rd), .rd_data(d_rdata), .flt_valid(d_fv), .flt_user(d_fu),
    .flt_write(d_fw), .flt_type(d_ft), .flt_va(d_fva), .miss_valid(d_mv),
    .miss_va(d_mva), .ctx_in(13'd0), .ctx_out(d_ctx_out)
  );

  mmu_ctl_bank #(.IS_DATA(1'b0)) u_dut_imm (
    .clk(clk), .rst_n(rst_n), .reg_addr(i_addr), .wr_en(i_wr), .wr_data(i_wdata),
    .rd_en(i_rd), .rd_data(i_rdata), .flt_valid(i_fv), .flt_user(i_fu),
    .flt_write(i_fw), .flt_type(i_ft), .flt_va(i_fva), .miss_valid(i_mv),
    .miss_va(i_mva), .ctx_in(d_ctx_out), .ctx_out(i_ctx_out)
  );

  // {index, write data, expected read-back} for the data side
  localparam logic [131:0] VECS [0:7] = '{
    {4'd1, 64'hFFFF_0000_0000_1ABC, 64'h0000_0000_0000_1ABC},
    {4'd2, 64'h0000_0000_0000_3FFF, 64'h0000_0000_0000_1FFF},
    {4'd5, 64'hDEAD_BEEF_0000_A005, 64'hDEAD_BEEF_0000_A005},
    {4'd6, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0},
    {4'd4, 64'h0000_0001_2345_6000, 64'h0000_0001_2345_6000},
    {4'd3, 64'h0000_0000_0000_0185, 64'h0000_0000_0000_0185},
    {4'd9, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0000},
    {4'd3, 64'h0000_0000_0000_0184, 64'h0000_0000_0000_0000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit s, input logic [3:0] idx, input logic [63:0] v);
    @(negedge clk);
    if (s) begin i_addr = idx; i_wdata = v; i_wr = 1; end
    else   begin d_addr = idx; d_wdata = v; d_wr = 1; end
    @(negedge clk);
    i_wr = 0; d_wr = 0;
  endtask

  task automatic rd(input bit s, input logic [3:0] idx, output logic [63:0] v);
    @(negedge clk);
    if (s) begin i_addr = idx; i_rd = 1; end
    else   begin d_addr = idx; d_rd = 1; end
    @(negedge clk);
    i_rd = 0; d_rd = 0;
    v = s ? i_rdata : d_rdata;
  endtask

  task automatic fault(input bit s, input logic u, input logic w, input logic [1:0] t,
                       input logic [63:0] va);
    @(negedge clk);
    if (s) begin i_fv = 1; i_fu = u; i_fw = w; i_ft = t; i_fva = va; end
    else   begin d_fv = 1; d_fu = u; d_fw = w; d_ft = t; d_fva = va; end
    @(negedge clk);
    i_fv = 0; d_fv = 0;
  endtask

  task automatic miss(input bit s, input logic [63:0] va);
    @(negedge clk);
    if (s) begin i_mv = 1; i_mva = va; end
    else   begin d_mv = 1; d_mva = va; end
    @(negedge clk);
    i_mv = 0; d_mv = 0;
  endtask

  function automatic logic [63:0] exp_tt(input logic [63:0] ta);
    return {3'b000, ta[12:0], 6'b000000, ta[63:22]};
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, held, ta;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, both sides
    for (int k = 0; k < 16; k++) begin
      rd(0, k[3:0], v); chk("R1 data side", v, 64'd0);
      rd(1, k[3:0], v); chk("R1 instr side", v, 64'd0);
    end

    // R2/R5: vector table on the data side
    for (int k = 0; k < 8; k++) begin
      wr(0, VECS[k][131:128], VECS[k][127:64]);
      rd(0, VECS[k][131:128], v);
      chk((VECS[k][131:128] == 4'd3) ? "R5 table" : "R2 table", v, VECS[k][63:0]);
    end
    rd(0, 4'd4, v); chk("R5 fault address cleared", v, 64'd0);
    chk("R11 ctx_out", {51'd0, d_ctx_out}, 64'h1ABC);

    // R3: tag target and ignored write
    ta = 64'h1234_5678_9ABC_DEF0;
    wr(0, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(0, 4'd0, v); chk("R3 tag target", v, exp_tt(ta));
    rd(0, 4'd6, v); chk("R3 tag unchanged", v, ta);

    // R6/R7: fault reporting
    fault(0, 1'b1, 1'b1, 2'b01, 64'h0000_0000_0BAD_F000);
    rd(0, 4'd3, v); chk("R6 first fault", v, 64'h8D);
    rd(0, 4'd4, v); chk("R7 fault address", v, 64'h0000_0000_0BAD_F000);
    fault(0, 1'b0, 1'b0, 2'b00, 64'h0000_0000_0CAF_E000);
    rd(0, 4'd3, v); chk("R6 overflow", v, 64'h3);

    // R9: fault beats a same-cycle clearing write
    wr(0, 4'd3, 64'd0);
    @(negedge clk);
    d_addr = 4'd3; d_wdata = 64'd0; d_wr = 1;
    d_fv = 1; d_fu = 1; d_fw = 0; d_ft = 2'b00; d_fva = 64'h0000_0000_0F00_D000;
    @(negedge clk);
    d_wr = 0; d_fv = 0;
    rd(0, 4'd3, v); chk("R9 fault over write", v, 64'h9);
    rd(0, 4'd4, v); chk("R9 fault address over clear", v, 64'h0000_0000_0F00_D000);

    // R8: miss capture with own primary context
    miss(0, 64'hFEDC_BA98_7654_3210);
    rd(0, 4'd6, v); chk("R8 miss data side", v, (64'hFEDC_BA98_7654_3210 & ~64'h1FFF) | 64'h1ABC);

    // R9: miss beats a same-cycle tag write
    @(negedge clk);
    d_addr = 4'd6; d_wdata = 64'h5555_5555_5555_5555; d_wr = 1;
    d_mv = 1; d_mva = 64'h0F0F_0F0F_0F0F_0F0F;
    @(negedge clk);
    d_wr = 0; d_mv = 0;
    rd(0, 4'd6, v); chk("R9 miss over write", v, (64'h0F0F_0F0F_0F0F_0F0F & ~64'h1FFF) | 64'h1ABC);

    // R4: read data holds without a strobe
    held = v;
    miss(0, 64'h0000_1111_2222_3333);
    chk("R4 read data holds", d_rdata, held);
    rd(0, 4'd6, v); chk("R4 new read", v, (64'h0000_1111_2222_3333 & ~64'h1FFF) | 64'h1ABC);

    // R10: instruction-side ignored indices
    wr(1, 4'd1, 64'h55); rd(1, 4'd1, v); chk("R10 instr index 1", v, 64'd0);
    wr(1, 4'd2, 64'h77); rd(1, 4'd2, v); chk("R10 instr index 2", v, 64'd0);
    wr(1, 4'd4, 64'h99); rd(1, 4'd4, v); chk("R10 instr index 4", v, 64'd0);
    wr(1, 4'd5, 64'h1111_2222_3333_4000); rd(1, 4'd5, v);
    chk("R10 instr TSB writable", v, 64'h1111_2222_3333_4000);
    wr(1, 4'd3, 64'h81); rd(1, 4'd3, v); chk("R5 instr status stored", v, 64'h81);

    // R6/R7 on the instruction side
    fault(1, 1'b1, 1'b0, 2'b01, 64'h0000_0000_0DEA_D000);
    rd(1, 4'd3, v); chk("R6 instr overflow", v, 64'h8B);
    rd(1, 4'd4, v); chk("R7 instr fault address zero", v, 64'd0);

    // R8: instruction side uses ctx_in
    miss(1, 64'h0000_7777_8888_9999);
    rd(1, 4'd6, v); chk("R8 miss instr side", v, (64'h0000_7777_8888_9999 & ~64'h1FFF) | 64'h1ABC);

    wr(1, 4'd3, 64'h40); rd(1, 4'd3, v); chk("R5 instr clear", v, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule